// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Controller

This block runs single transactions to external memory or peripherals over a shared 16-bit address/data bus. It drives an address-latch strobe and active-low read and write strobes. Each request comes from a simple internal valid/ready port and carries a 32-bit address, a direction and, for writes, 16 bits of data. The controller turns the request into an optional address-latch cycle followed by one data cycle. During the latch cycle the upper 16 address bits go onto the shared lines, so that an external transparent latch can capture them while the strobe is high.

The controller keeps the last upper address it sent to the external latch. When a request shares that upper half, the latch cycle is skipped and the data cycle starts at once. The stored copy is dropped whenever the port is disabled, so the first access after enabling always latches. The external bus runs in port cycles of `DIV` core clocks (3 by default). The latch cycle is always one port cycle long and its strobe is high for `ALE_HIGH` core clocks (2 by default). The data cycle lasts a programmable number of port cycles.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is asserted and while no transaction is in progress: `ale` = 0, `rd_n` = 1, `wr_n` = 1, `ad_oe` = 0, `rsp_valid` = 0, and `req_ready` equals `enable`.
- R2: An address-latch cycle lasts exactly 3 core clocks. Throughout it, `ad_oe` = 1, `ad_out` = request address bits [31:16], and both `rd_n` and `wr_n` are 1.
- R3: `ale` is high for exactly the first 2 core clocks of every latch cycle and low in the third, whatever `data_len` is.
- R4: The first accepted request after reset, and the first after `enable` rises, always begins with a latch cycle.
- R5: A latch cycle is inserted when address bits [31:16] differ from those of the previous accepted request. When they are equal, the data cycle starts in the first clock after acceptance.
- R6: A data cycle keeps its strobe low for 3 × L core clocks, where L = `data_len`, or 1 when `data_len` is 0. `data_len` is sampled at acceptance, and later changes do not affect the transaction in progress.
- R7: In a write data cycle (`req_write` = 1), `wr_n` = 0, `rd_n` = 1, `ad_oe` = 1 and `ad_out` = the write data for every clock of the cycle.
- R8: In a read data cycle, `rd_n` = 0, `wr_n` = 1 and `ad_oe` = 0. `ad_in` is sampled at the end of the last core clock with `rd_n` low. In the next clock `rsp_valid` is 1 for exactly one clock and `rsp_rdata` holds that sample.
- R9: `req_ready` is 0 from the clock after acceptance until the data cycle has ended, and it is 0 whenever `enable` is 0. No request is taken while `enable` is 0.
- R10: `rd_n` and `wr_n` are never low together, and `ale` is never high while either strobe is low.
- R11: Dropping `enable` discards the stored upper address. A request after re-enabling latches even if its upper half equals the last one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low discards the stored upper address |
| data_len | input | 4 | Data-cycle length in port cycles (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transaction address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Value seen on the shared lines |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench sweeps every data length from 0 to 5 in both directions. Each length is tried once with a new upper address and once with a repeated one, so that both the latched and the skipped paths are timed clock by clock. Several faults are aimed at directly. A length of 0 taken literally would give a cycle of 16 or 0 port cycles. Reading `data_len` live would stretch or cut a cycle when the input moves mid-transaction. A tracker that is not cleared on disable would skip the latch cycle after re-enable. `ad_in` changes every clock, so sampling one clock early or late returns the wrong word.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  localparam int ADDR_W = 32;
  localparam int BUS_W  = 16;
  localparam int UP_W   = ADDR_W - BUS_W;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LATCH = 2'd1,
    SEQ_DATA  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
  } bus_req_t;

  // upper half of an address, the part carried by the latch cycle
  function automatic logic [UP_W-1:0] upper_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BUS_W];
  endfunction

endpackage

// File: rtl/mbc_phase_div.sv
// Core-clock phase counter inside one port cycle; held at zero when idle.
module mbc_phase_div #(
  parameter int DIV = 3,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          last
);

  localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);

  assign last = run && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run || last) begin
      phase <= '0;
    end else begin
      phase <= phase + PW'(1);
    end
  end

endmodule

// File: rtl/mbc_upper_track.sv
// Remembers the upper address last sent to the external latch.
module mbc_upper_track
  import mux_bus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            load,
  input  logic [UP_W-1:0] upper_in,
  output logic            valid,
  output logic [UP_W-1:0] upper_q,
  output logic            miss
);

  assign miss = !valid || (upper_in != upper_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      upper_q <= '0;
    end else if (!enable) begin
      valid <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      upper_q <= upper_in;
    end
  end

endmodule

// File: rtl/mbc_seq.sv
// Transaction sequencer: idle -> optional latch cycle -> data cycle.
module mbc_seq
  import mux_bus_pkg::*;
#(
  parameter int DIV      = 3,
  parameter int ALE_HIGH = 2,
  parameter int LEN_W    = 4,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             req_valid,
  input  bus_req_t         req_in,
  input  logic [LEN_W-1:0] data_len,
  input  logic [BUS_W-1:0] ad_in,
  input  logic [PW-1:0]    phase,
  input  logic             phase_last,
  input  logic             upper_miss,
  output logic             req_ready,
  output logic             load_upper,
  output logic             busy,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n
);

  localparam logic [PW-1:0] ALE_LIM = PW'(ALE_HIGH);

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] n);
    return (n == '0) ? LEN_W'(1) : n;
  endfunction

  seq_state_t       state;
  bus_req_t         req_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] beat_q;

  logic accept;
  logic latch_done;
  logic data_done;
  logic in_latch;
  logic in_data;

  assign in_latch   = (state == SEQ_LATCH);
  assign in_data    = (state == SEQ_DATA);
  assign busy       = (state != SEQ_IDLE);
  assign req_ready  = enable && !busy;
  assign accept     = req_valid && req_ready;
  assign load_upper = accept && upper_miss;
  assign latch_done = in_latch && phase_last;
  assign data_done  = in_data && phase_last && (beat_q == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      req_q     <= '0;
      len_q     <= LEN_W'(1);
      beat_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            req_q  <= req_in;
            len_q  <= eff_len(data_len);
            beat_q <= '0;
            state  <= upper_miss ? SEQ_LATCH : SEQ_DATA;
          end
        end
        SEQ_LATCH: begin
          if (latch_done) state <= SEQ_DATA;
        end
        SEQ_DATA: begin
          if (data_done) begin
            state <= SEQ_IDLE;
            if (!req_q.wr) begin
              rsp_rdata <= ad_in;
              rsp_valid <= 1'b1;
            end
          end else if (phase_last) begin
            beat_q <= beat_q + LEN_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ale    = in_latch && (phase < ALE_LIM);
    rd_n   = !(in_data && !req_q.wr);
    wr_n   = !(in_data && req_q.wr);
    ad_oe  = in_latch || (in_data && req_q.wr);
    ad_out = '0;
    if (in_latch) ad_out = upper_of(req_q.addr);
    else if (in_data && req_q.wr) ad_out = req_q.wdata;
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int DIV      = 3,
  parameter int ALE_HIGH = 2,
  parameter int LEN_W    = 4,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  input  logic [BUS_W-1:0]  ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  bus_req_t        req_in;
  logic [PW-1:0]   phase;
  logic            phase_last;
  logic            seq_busy;
  logic            load_upper;
  logic            trk_valid;
  logic [UP_W-1:0] trk_upper;
  logic            upper_miss;

  assign req_in = '{wr: req_write, addr: req_addr, wdata: req_wdata};

  mbc_phase_div #(.DIV(DIV)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (seq_busy),
    .phase (phase),
    .last  (phase_last)
  );

  mbc_upper_track trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .load     (load_upper),
    .upper_in (upper_of(req_addr)),
    .valid    (trk_valid),
    .upper_q  (trk_upper),
    .miss     (upper_miss)
  );

  mbc_seq #(.DIV(DIV), .ALE_HIGH(ALE_HIGH), .LEN_W(LEN_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .req_valid  (req_valid),
    .req_in     (req_in),
    .data_len   (data_len),
    .ad_in      (ad_in),
    .phase      (phase),
    .phase_last (phase_last),
    .upper_miss (upper_miss),
    .req_ready  (req_ready),
    .load_upper (load_upper),
    .busy       (seq_busy),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk
  import mux_bus_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [BUS_W-1:0] ad_out,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            busy,
  input logic            trk_valid,
  input logic [UP_W-1:0] trk_upper
);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_ale_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  assert_ale_two_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

  assert_ale_then_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);

  assert_latch_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && trk_valid && ad_out == trk_upper));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_disabled_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_ready);

  assert_read_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> rsp_valid);

  assert_tracker_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !trk_valid);

endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .busy      (seq_busy),
  .trk_valid (trk_valid),
  .trk_upper (trk_upper)
);

// File: tb/mux_bus_ctrl_tb_top.sv
`timescale 1ns/100ps
module mux_bus_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [3:0]  data_len = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = '0;
  logic        ale;
  logic        rd_n;
  logic        wr_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the upper-address tracker
  bit        m_valid = 1'b0;
  bit [15:0] m_upper = '0;

  always #2.5 clk = ~clk;

  mux_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .data_len(data_len),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // {ale, rd_n, wr_n, ad_oe, req_ready, rsp_valid}
  function automatic logic [5:0] pins();
    return {ale, rd_n, wr_n, ad_oe, req_ready, rsp_valid};
  endfunction

  task automatic check_idle(input string req, input bit exp_rsp);
    logic [5:0] e;
    e = {1'b0, 1'b1, 1'b1, 1'b0, enable, exp_rsp};
    check(pins() == e, req, "idle pins", 32'(pins()), 32'(e));
  endtask

  task automatic run_txn(input bit wr, input logic [31:0] addr, input logic [15:0] wd,
                         input logic [3:0] len, input logic [15:0] pat);
    bit         lat;
    int         nlen;
    int         total;
    int         w;
    logic [5:0] e;
    lat   = !m_valid || (addr[31:16] != m_upper);
    nlen  = (len == 4'd0) ? 1 : int'(len);
    total = (lat ? 3 : 0) + 3 * nlen;
    w = 0;
    while (!req_ready && w < 100) begin
      @(negedge clk);
      w++;
    end
    req_write = wr; req_addr = addr; req_wdata = wd; data_len = len; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    data_len  = ~len;                 // must not affect this transaction (R6)
    m_valid   = 1'b1;
    m_upper   = addr[31:16];
    for (int i = 0; i < total; i++) begin
      ad_in = pat ^ 16'(i);
      if (lat && i < 3) begin
        e = {(i < 2), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        check(pins() == e, (i == 0) ? "R4/R5 latch R3" : "R2 R3", "latch pins",
              32'(pins()), 32'(e));
        check(ad_out == addr[31:16], "R2", "latch addr", 32'(ad_out), 32'(addr[31:16]));
      end else begin
        e = {1'b0, wr, !wr, wr, 1'b0, 1'b0};
        check(pins() == e, (i == 0 && !lat) ? "R5 skip R6" : (wr ? "R7 R6" : "R8 R6"),
              "data pins", 32'(pins()), 32'(e));
        if (wr) check(ad_out == wd, "R7", "write data", 32'(ad_out), 32'(wd));
      end
      @(negedge clk);
    end
    check_idle("R6 R9 end", !wr);
    if (!wr) check(rsp_rdata == (pat ^ 16'(total - 1)), "R8", "read sample",
                   32'(rsp_rdata), 32'(pat ^ 16'(total - 1)));
    if (!wr) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R8", "pulse width", 32'(rsp_valid), 32'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset", 1'b0);

    // first access after reset, upper half zero, still latches (R4)
    run_txn(1'b0, 32'h0000_0010, 16'h0, 4'd1, 16'h5A00);

    // sweep lengths and directions, new upper then repeated upper (R5 R6 R7 R8)
    for (int len = 0; len < 6; len++) begin
      for (int wr = 0; wr < 2; wr++) begin
        logic [15:0] up;
        up = 16'h1000 + 16'(len * 2 + wr);
        run_txn(wr[0], {up, 16'h0100}, 16'hC300 + 16'(len), 4'(len), 16'h3C00 + 16'(len));
        run_txn(wr[0], {up, 16'h0202}, 16'hA500 + 16'(len), 4'(len), 16'h6900 + 16'(len));
      end
    end

    // disable: requests refused, bus quiet (R9), tracker dropped (R11)
    @(negedge clk);
    enable = 1'b0;
    m_valid = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = {m_upper, 16'h0}; data_len = 4'd2;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R9", "ready while disabled", 32'(req_ready), 32'(0));
      check(pins() == 6'b011000, "R9", "bus quiet while disabled", 32'(pins()), 32'(6'b011000));
    end
    req_valid = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    check_idle("R1 R9 re-enabled", 1'b0);
    run_txn(1'b1, {m_upper, 16'h0040}, 16'hBEEF, 4'd2, 16'h0);   // R11: latch expected
    run_txn(1'b0, {m_upper, 16'h0044}, 16'h0, 4'd3, 16'h7700);   // R5: skip
    run_txn(1'b1, 32'hFFFF_0000, 16'h1234, 4'd15, 16'h0);        // long cycle R6
    run_txn(1'b0, 32'h0000_FFFF, 16'h0, 4'd0, 16'h8800);         // R5 change back

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule